// File: doc/BRIEF.md
# Cable Crossover Resolver

This block settles the transmit/receive pair orientation of a single Ethernet port when the attached PHY cannot do so by itself. It owns one select output that chooses straight-through (MDI, output low) or crossed (MDIX, output high) wiring. It reaches the PHY through a command/status access register: each PHY read is a command write, followed by repeated reads until a busy flag clears.

After a start pulse the block polls the PHY's extended status register until the PHY reports a received signal. It then drives MDI and enters a loop. Each pass waits a fixed interval, reads the basic status register, and ends with success if link is up. Otherwise it flips the select and tries again. Both loops have a fixed bound. When the sequence ends, `done` rises and `ok` gives the result. Both stay put, with the select, until the next start.

The interval length comes from a clock-frequency parameter and a millisecond parameter, so a fast test setup can shorten it.

Top module: `xover_top`

## Requirements
- R1: Every access write carries bit 31 = 1 (request/busy), bit 30 = 0 (read), the PHY address `PHY_ADDR` (default 6) in bits 25:21, the PHY register number in bits 20:16, and zeros in bits 15:0.
- R2: After a write the block issues reads until a reply has bit 31 = 0. Replies with bit 31 = 1 are treated as busy and their other bits are ignored. The PHY data is taken from bits 15:0 of the first non-busy reply.
- R3: The signal phase reads PHY register `SIG_REG` (default 17) and leaves the phase as soon as bit 1 of the returned data is 1.
- R4: The signal phase makes at most `SIG_TRIES-1` reads (99 by default). If none shows a signal, the block finishes with `ok`=0, `mdix_sel`=0, and never reads the link register.
- R5: `mdix_sel` is 0 (MDI) throughout the signal phase and when the first link attempt is made.
- R6: Each link attempt waits at least `CLK_HZ/1000*WAIT_MS` clock cycles, measured from the end of the previous access, and then reads PHY register `LINK_REG` (default 1). Link is up when bit 2 of the data is 1.
- R7: Every link attempt that finds link down inverts `mdix_sel`, so attempt k (counting from 1) is made with `mdix_sel` = (k-1) mod 2.
- R8: Link up ends the sequence with `done`=1, `ok`=1 and the select unchanged. After `LINK_TRIES-1` failed attempts (99 by default) the block finishes with `ok`=0. `ok` is never 1 while `done` is 0.
- R9: After reset `done`, `ok`, `mdix_sel` and both strobes are 0. A `start` pulse while idle clears `done` and `ok` and launches the sequence. A `start` pulse while the sequence runs has no effect. `done`, `ok` and `mdix_sel` hold until the next start.
- R10: `reg_wr` and `reg_rd` are single-cycle strobes and are never high together. Read data is sampled on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| reg_wr | output | 1 | Access-register write strobe |
| reg_wdata | output | 32 | Command word for the write |
| reg_rd | output | 1 | Access-register read strobe |
| reg_rdata | input | 32 | Read reply, valid the cycle after `reg_rd` |
| mdix_sel | output | 1 | Crossover select: 0 = MDI, 1 = MDIX |
| done | output | 1 | Sequence finished, held until next start |
| ok | output | 1 | Result of the finished sequence |

## Verification
The assertions check the rules that hold on every cycle. Every command word must have the right header and address. The strobes must be exclusive single pulses. `ok` must imply `done`. MDI must be held while the signal register is being requested. The block must stay quiet, with stable outputs, once finished. The bench scenarios are needed for the behaviour that spans a whole sequence: the exact number of signal and link reads at each retry bound, the alternation of the select across link attempts, the minimum interval before each link read, the use of the payload only from non-busy replies, and a start pulse arriving mid-run being ignored.

// File: rtl/xover_pkg.sv
package xover_pkg;

  localparam int CMD_W    = 32;
  localparam int DATA_W   = 16;
  localparam int BUSY_BIT = 31;
  localparam int DIR_BIT  = 30;
  localparam int ADDR_LSB = 21;
  localparam int REG_LSB  = 16;
  localparam int FLD_W    = 5;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_POLL,
    ACC_HOLD,
    ACC_SAMP
  } acc_state_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SIGNAL,
    SEQ_PAUSE,
    SEQ_LINK
  } seq_state_t;

  function automatic logic [CMD_W-1:0] read_cmd(input logic [FLD_W-1:0] phy,
                                                input logic [FLD_W-1:0] regn);
    logic [CMD_W-1:0] w;
    w = '0;
    w[BUSY_BIT] = 1'b1;
    w[DIR_BIT]  = 1'b0;
    w[ADDR_LSB +: FLD_W] = phy;
    w[REG_LSB  +: FLD_W] = regn;
    return w;
  endfunction

endpackage

// File: rtl/xover_phy_rd.sv
module xover_phy_rd
  import xover_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [CMD_W-1:0]  cmd,
  output logic              reg_wr,
  output logic [CMD_W-1:0]  reg_wdata,
  output logic              reg_rd,
  input  logic [CMD_W-1:0]  reg_rdata,
  output logic              fin,
  output logic [DATA_W-1:0] rdat
);

  acc_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ACC_IDLE;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_rd    <= 1'b0;
      fin       <= 1'b0;
      rdat      <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        ACC_IDLE: begin
          if (go) begin
            reg_wr    <= 1'b1;
            reg_wdata <= cmd;
            st        <= ACC_POLL;
          end
        end
        ACC_POLL: begin
          reg_wr <= 1'b0;
          reg_rd <= 1'b1;
          st     <= ACC_HOLD;
        end
        ACC_HOLD: begin
          reg_rd <= 1'b0;
          st     <= ACC_SAMP;
        end
        ACC_SAMP: begin
          if (reg_rdata[BUSY_BIT]) begin
            reg_rd <= 1'b1;
            st     <= ACC_HOLD;
          end else begin
            fin  <= 1'b1;
            rdat <= reg_rdata[DATA_W-1:0];
            st   <= ACC_IDLE;
          end
        end
        default: st <= ACC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xover_tick.sv
module xover_tick #(
  parameter int unsigned CYC = 15_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic expire
);

  localparam int unsigned CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LOADV = CW'(CYC - 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      run    <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (kick) begin
        cnt <= LOADV;
        run <= 1'b1;
      end else if (run) begin
        if (cnt == '0) begin
          run    <= 1'b0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/xover_tries.sv
module xover_tries #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt <= W'(1));

endmodule

// File: rtl/xover_top.sv
module xover_top
  import xover_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned WAIT_MS    = 300,
  parameter int unsigned SIG_TRIES  = 100,
  parameter int unsigned LINK_TRIES = 100,
  parameter int unsigned PHY_ADDR   = 6,
  parameter int unsigned SIG_REG    = 17,
  parameter int unsigned SIG_BIT    = 1,
  parameter int unsigned LINK_REG   = 1,
  parameter int unsigned LINK_BIT   = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        reg_wr,
  output logic [31:0] reg_wdata,
  output logic        reg_rd,
  input  logic [31:0] reg_rdata,
  output logic        mdix_sel,
  output logic        done,
  output logic        ok
);

  localparam int unsigned WAIT_CYC = (CLK_HZ / 1000) * WAIT_MS;
  localparam int unsigned MAXT     = (SIG_TRIES > LINK_TRIES) ? SIG_TRIES : LINK_TRIES;
  localparam int unsigned TW       = $clog2(MAXT + 1);
  localparam logic [TW-1:0] SIG_LD  = TW'(SIG_TRIES - 1);
  localparam logic [TW-1:0] LINK_LD = TW'(LINK_TRIES - 1);
  localparam logic [CMD_W-1:0] SIG_CMD  = read_cmd(FLD_W'(PHY_ADDR), FLD_W'(SIG_REG));
  localparam logic [CMD_W-1:0] LINK_CMD = read_cmd(FLD_W'(PHY_ADDR), FLD_W'(LINK_REG));

  seq_state_t         st;
  logic               acc_go;
  logic [CMD_W-1:0]   acc_cmd;
  logic               acc_fin;
  logic [DATA_W-1:0]  acc_dat;
  logic               tmr_kick;
  logic               tmr_exp;
  logic               try_load;
  logic [TW-1:0]      try_val;
  logic               try_dec;
  logic               try_last;

  xover_phy_rd u_acc (
    .clk       (clk),
    .rst       (rst),
    .go        (acc_go),
    .cmd       (acc_cmd),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .fin       (acc_fin),
    .rdat      (acc_dat)
  );

  xover_tick #(.CYC(WAIT_CYC)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .kick   (tmr_kick),
    .expire (tmr_exp)
  );

  xover_tries #(.W(TW)) u_tries (
    .clk      (clk),
    .rst      (rst),
    .load     (try_load),
    .load_val (try_val),
    .dec      (try_dec),
    .last     (try_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SEQ_IDLE;
      acc_go   <= 1'b0;
      acc_cmd  <= '0;
      tmr_kick <= 1'b0;
      try_load <= 1'b0;
      try_val  <= '0;
      try_dec  <= 1'b0;
      mdix_sel <= 1'b0;
      done     <= 1'b0;
      ok       <= 1'b0;
    end else begin
      acc_go   <= 1'b0;
      tmr_kick <= 1'b0;
      try_load <= 1'b0;
      try_dec  <= 1'b0;
      case (st)
        SEQ_IDLE: begin
          if (start) begin
            done     <= 1'b0;
            ok       <= 1'b0;
            mdix_sel <= 1'b0;
            try_load <= 1'b1;
            try_val  <= SIG_LD;
            if (SIG_TRIES < 2) begin
              done <= 1'b1;
            end else begin
              acc_cmd <= SIG_CMD;
              acc_go  <= 1'b1;
              st      <= SEQ_SIGNAL;
            end
          end
        end
        SEQ_SIGNAL: begin
          if (acc_fin) begin
            if (acc_dat[SIG_BIT]) begin
              mdix_sel <= 1'b0;
              try_load <= 1'b1;
              try_val  <= LINK_LD;
              if (LINK_TRIES < 2) begin
                done <= 1'b1;
                st   <= SEQ_IDLE;
              end else begin
                tmr_kick <= 1'b1;
                st       <= SEQ_PAUSE;
              end
            end else if (try_last) begin
              done <= 1'b1;
              st   <= SEQ_IDLE;
            end else begin
              try_dec <= 1'b1;
              acc_cmd <= SIG_CMD;
              acc_go  <= 1'b1;
            end
          end
        end
        SEQ_PAUSE: begin
          if (tmr_exp) begin
            acc_cmd <= LINK_CMD;
            acc_go  <= 1'b1;
            st      <= SEQ_LINK;
          end
        end
        SEQ_LINK: begin
          if (acc_fin) begin
            if (acc_dat[LINK_BIT]) begin
              done <= 1'b1;
              ok   <= 1'b1;
              st   <= SEQ_IDLE;
            end else begin
              mdix_sel <= ~mdix_sel;
              if (try_last) begin
                done <= 1'b1;
                st   <= SEQ_IDLE;
              end else begin
                try_dec  <= 1'b1;
                tmr_kick <= 1'b1;
                st       <= SEQ_PAUSE;
              end
            end
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xover_chk.sv
module xover_chk #(
  parameter int unsigned PHY_ADDR = 6,
  parameter int unsigned SIG_REG  = 17
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic        reg_rd,
  input logic        mdix_sel,
  input logic        done,
  input logic        ok
);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

  p_wr_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  p_rd_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);

  p_cmd_hdr_r1: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> (reg_wdata[31] && !reg_wdata[30] &&
                reg_wdata[25:21] == 5'(PHY_ADDR) && reg_wdata[15:0] == 16'h0));

  p_ok_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
    ok |-> done);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(ok) && $stable(mdix_sel)));

  p_quiet_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!reg_wr && !reg_rd));

  p_mdi_in_signal_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[20:16] == 5'(SIG_REG)) |-> !mdix_sel);

endmodule

bind xover_top xover_chk #(.PHY_ADDR(PHY_ADDR), .SIG_REG(SIG_REG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rd    (reg_rd),
  .mdix_sel  (mdix_sel),
  .done      (done),
  .ok        (ok)
);

// File: tb/xover_top_tb.sv
`timescale 1ns/1ps
module xover_top_tb;

  localparam int CLK_HZ = 20000;
  localparam int WMS    = 1;
  localparam int WCYC   = (CLK_HZ / 1000) * WMS;
  localparam int SIGN   = 100;
  localparam int LINKN  = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata = '0;
  logic        mdix_sel, done, ok;

  xover_top #(.CLK_HZ(CLK_HZ), .WAIT_MS(WMS), .SIG_TRIES(SIGN), .LINK_TRIES(LINKN)) u_dut (
    .clk(clk), .rst(rst), .start(start), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .mdix_sel(mdix_sel), .done(done), .ok(ok)
  );

  always #10 clk = ~clk;

  int ntests = 0;
  int nfail  = 0;

  // scenario controls, driven by the initial block only
  int sig_at = 0, link_at = 0, busy_max = 0;
  logic clr = 1'b0;

  // PHY responder state and observations
  int cyc = 0, busy_left = 0, cur_reg = 0, last_end = 0;
  int sig_cnt = 0, link_cnt = 0, fmt_err = 0, gap_err = 0, sel_err = 0, bad_reg = 0;

  always @(posedge clk) begin
    logic [15:0] lo;
    logic [31:0] rnd;
    cyc <= cyc + 1;
    rnd = $urandom;
    if (clr) begin
      sig_cnt <= 0; link_cnt <= 0; fmt_err <= 0; gap_err <= 0;
      sel_err <= 0; bad_reg <= 0; busy_left <= 0; last_end <= cyc;
    end else begin
      if (reg_wr) begin
        cur_reg   <= int'(reg_wdata[20:16]);
        busy_left <= (busy_max == 0) ? 0 : int'($urandom_range(busy_max, 0));
        if (reg_wdata[31] !== 1'b1 || reg_wdata[30] !== 1'b0 ||
            reg_wdata[25:21] !== 5'd6 || reg_wdata[15:0] !== 16'h0)
          fmt_err <= fmt_err + 1;
        if (reg_wdata[20:16] == 5'd1) begin
          if (cyc - last_end < WCYC) gap_err <= gap_err + 1;
          if (mdix_sel !== 1'((link_cnt) & 1)) sel_err <= sel_err + 1;
        end
      end
      if (reg_rd) begin
        if (busy_left > 0) begin
          busy_left <= busy_left - 1;
          reg_rdata <= 32'h8000_0000 | rnd;
        end else begin
          last_end <= cyc;
          lo = rnd[15:0];
          if (cur_reg == 17) begin
            lo[1] = (sig_at != 0 && sig_cnt + 1 == sig_at);
            sig_cnt <= sig_cnt + 1;
          end else if (cur_reg == 1) begin
            lo[2] = (link_at != 0 && link_cnt + 1 == link_at);
            link_cnt <= link_cnt + 1;
          end else begin
            bad_reg <= bad_reg + 1;
          end
          reg_rdata <= {1'b0, rnd[30:16], lo};
        end
      end
    end
  end

  function automatic bit exp_sig_ok(int sa);
    return (sa >= 1 && sa <= SIGN - 1);
  endfunction
  function automatic bit exp_link_ok(int sa, int la);
    return exp_sig_ok(sa) && la >= 1 && la <= LINKN - 1;
  endfunction
  function automatic int exp_sig_reads(int sa);
    return exp_sig_ok(sa) ? sa : SIGN - 1;
  endfunction
  function automatic int exp_link_reads(int sa, int la);
    if (!exp_sig_ok(sa)) return 0;
    return exp_link_ok(sa, la) ? la : LINKN - 1;
  endfunction
  function automatic int exp_sel(int sa, int la);
    if (!exp_sig_ok(sa)) return 0;
    return exp_link_ok(sa, la) ? ((la - 1) & 1) : ((LINKN - 1) & 1);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int sa, input int la, input int bm, input bit poke);
    int t;
    int sel_now;
    @(negedge clk);
    sig_at = sa; link_at = la; busy_max = bm; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "done cleared by start", int'(done), 0);
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1;                       // R9: must be ignored mid-run
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk("R9", "sequence finished", int'(done), 1);
    chk("R3", "signal reads", sig_cnt, exp_sig_reads(sa));
    chk("R4", "link reads", link_cnt, exp_link_reads(sa, la));
    chk("R8", "ok", int'(ok), int'(exp_link_ok(sa, la)));
    chk("R7", "final select", int'(mdix_sel), exp_sel(sa, la));
    chk("R7", "select per attempt errors", sel_err, 0);
    chk("R6", "interval errors", gap_err, 0);
    chk("R1", "command format errors", fmt_err, 0);
    chk("R2", "unexpected register reads", bad_reg, 0);
    sel_now = int'(mdix_sel);
    repeat (15) @(negedge clk);
    chk("R9", "done held", int'(done), 1);
    chk("R9", "select held", int'(mdix_sel), sel_now);
    chk("R10", "no strobes after done", int'(reg_wr | reg_rd), 0);
  endtask

  initial begin
    void'($urandom(32'd20240613));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "reset done", int'(done), 0);
    chk("R9", "reset ok", int'(ok), 0);
    chk("R5", "reset select", int'(mdix_sel), 0);
    chk("R10", "reset strobes", int'(reg_wr | reg_rd), 0);

    run(1, 1, 0, 0);          // R8: immediate success
    run(3, 2, 2, 0);          // R2: busy replies, R7 one toggle
    run(6, 4, 1, 1);          // R9: start pulse mid-run ignored
    run(0, 1, 0, 0);          // R4: signal never seen
    run(SIGN - 1, 1, 0, 0);   // R4: signal on last permitted read
    run(SIGN, 1, 0, 0);       // R4: signal one read too late
    run(2, 0, 1, 0);          // R8: link never, bound exhausted
    run(1, LINKN - 1, 0, 0);  // R8: link on last permitted attempt
    run(1, LINKN, 0, 0);      // R8: link one attempt too late
    for (int i = 0; i < 8; i++) begin
      run(int'($urandom_range(12, 1)), int'($urandom_range(15, 1)),
          int'($urandom_range(3, 0)), 1'($urandom_range(1, 0)));
    end
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    ntests++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule